// File: doc/BRIEF.md
# Charge-Transfer Switch Phase Sequencer

This block issues the enable lines for the ten analog switches that carry out one pixel's capacitive charge-transfer measurement. It precharges the sense electrode to the high reference and the dummy cancel cell to the low reference, moves charge into the sense amplifier and its hold capacitor, resets the output amplifier input, and finally moves the held charge into the output hold capacitor. The make/break ordering is fixed so that the dummy cell's charge cancels the electrode's parasitic capacitance. It is not a generic two-phase clock.

A one-cycle `start` request is honoured only while the sequencer is idle. Each of the nine steps lasts `DWELL` clocks. Between two steps the sequencer inserts a single gap cycle. In that cycle only the switches that are on in both neighbouring steps stay on, so every break happens before any make. When the run ends, all switches drop and `done` pulses. The 3-bit gain code is captured when a run is accepted. From that code the block derives the codes for the high charge level and the mirrored low charge level.

Top module: `ctx_switch_seq`

## Requirements
- R1: While reset is held and whenever the block is idle, `sw_en` is all zero and `busy` is low. After reset, `done` is low and `gain_code` is 0.
- R2: When `start` is high in an idle cycle, the next cycle shows `busy` high and the first step's pattern: S1, S4, Sr and S11 on. The bit positions are S1=0, S2=1, S3=2, S4=3, S5=4, S6=5, S7=6, Sr=7, Sc=8, S11=9.
- R3: The step patterns are, in order: {S1,S4,Sr,S11}, {S4}, {S2,S4}, {S2}, {S2,S3,S5,Sr}, {S2,S3,Sr}, {S2,S3,S6,Sr}, {S2,S3,Sr}, {S2,S3,S7,Sr,Sc}.
- R4: Every step holds its pattern for exactly `DWELL` cycles (default 2). A run keeps `busy` high for 9·DWELL+8 cycles.
- R5: Between consecutive steps there is exactly one gap cycle showing the AND of the two patterns. No cycle has one switch turning on while another turns off.
- R6: After the last step, `sw_en` returns to zero and `busy` falls. In that same cycle `done` is high, and it stays high for one cycle only.
- R7: `start` while `busy` is high is ignored. The run continues unchanged and `gain_code` is not reloaded.
- R8: `gain_code` takes the value of `gain_in` only in the cycle after an accepted start. Changes of `gain_in` at other times have no effect.
- R9: `lvl_high` = 192 + 8·`gain_code` and `lvl_low` = 368 − `lvl_high`. The code range is 192..248 for the high level and 176..120 for the low level.
- R10: S1 is never on together with S2, S3 or S5. S5 and S6 are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Run request, honoured only while idle |
| gain_in | input | 3 | Gain code offered with the request; bit 0 is the LSB |
| sw_en | output | 10 | Switch enables, bit map as in R2 |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when a run completes |
| gain_code | output | 3 | Gain code captured at acceptance |
| lvl_high | output | 8 | Code for the high charge level |
| lvl_low | output | 8 | Code for the mirrored low charge level |

## Verification
Directed runs with gain codes 0 and 7 pin the two ends of the level range. Random runs with random codes show that the latch takes its value only at acceptance. During each run, `start` and `gain_in` are toggled at random, which tells a correctly ignored retrigger apart from a restart or a reload of the gain. Every cycle of every run is compared against a step/gap timeline computed by the bench, so a shifted gap, a wrong intersection or a wrong dwell shows up as a mismatch in a specific cycle. Idle stretches between runs, with `gain_in` wandering, check that the switches stay off and the code holds. A run launched in the same cycle as `done` checks back-to-back acceptance.

// File: rtl/ctx_seq_pkg.sv
package ctx_seq_pkg;

  localparam int NSW   = 10;
  localparam int NSTEP = 9;
  localparam int IDX_W = 4;

  // Switch bit positions on sw_en
  localparam int SW_S1  = 0;
  localparam int SW_S2  = 1;
  localparam int SW_S3  = 2;
  localparam int SW_S4  = 3;
  localparam int SW_S5  = 4;
  localparam int SW_S6  = 5;
  localparam int SW_S7  = 6;
  localparam int SW_SR  = 7;
  localparam int SW_SC  = 8;
  localparam int SW_S11 = 9;

  typedef logic [NSW-1:0] sw_vec_t;

  function automatic sw_vec_t bitv(input int pos);
    sw_vec_t v;
    v = '0;
    v[pos] = 1'b1;
    return v;
  endfunction

  // Pattern held during step idx (1..NSTEP); idle and out of range give zero
  function automatic sw_vec_t step_pattern(input int idx);
    sw_vec_t core;
    core = bitv(SW_S2) | bitv(SW_S3) | bitv(SW_SR);
    case (idx)
      1: return bitv(SW_S1) | bitv(SW_S4) | bitv(SW_SR) | bitv(SW_S11);
      2: return bitv(SW_S4);
      3: return bitv(SW_S2) | bitv(SW_S4);
      4: return bitv(SW_S2);
      5: return core | bitv(SW_S5);
      6: return core;
      7: return core | bitv(SW_S6);
      8: return core;
      9: return core | bitv(SW_S7) | bitv(SW_SC);
      default: return '0;
    endcase
  endfunction

  // Pattern shown in the gap after step idx: only switches common to both sides
  function automatic sw_vec_t gap_pattern(input int idx);
    return step_pattern(idx) & step_pattern(idx + 1);
  endfunction

  function automatic int unsigned lvl_high_of(input logic [2:0] g,
                                              input int unsigned base,
                                              input int unsigned step);
    return base + step * int'(g);
  endfunction

  function automatic int unsigned lvl_low_of(input int unsigned hi,
                                             input int unsigned mid);
    return 2 * mid - hi;
  endfunction

endpackage

// File: rtl/ctx_dwell_timer.sv
module ctx_dwell_timer #(
  parameter int DWELL = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expire
);
  localparam int CW = (DWELL > 1) ? $clog2(DWELL) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(DWELL - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= RELOAD;
    end else if (run && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire = run && (cnt_q == '0);

endmodule

// File: rtl/ctx_phase_fsm.sv
module ctx_phase_fsm
  import ctx_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             expire,
  output logic [IDX_W-1:0] idx_q,
  output logic             gap_q,
  output logic [IDX_W-1:0] idx_d,
  output logic             gap_d,
  output logic             accept,
  output logic             load,
  output logic             run,
  output logic             last_end,
  output logic             done_q
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NSTEP);

  always_comb begin
    idx_d    = idx_q;
    gap_d    = gap_q;
    accept   = start && (idx_q == '0);
    last_end = expire && (idx_q == IDX_LAST);
    if (accept) begin
      idx_d = IDX_W'(1);
      gap_d = 1'b0;
    end else if (gap_q) begin
      idx_d = idx_q + 1'b1;
      gap_d = 1'b0;
    end else if (expire) begin
      if (idx_q == IDX_LAST) begin
        idx_d = '0;
      end else begin
        gap_d = 1'b1;
      end
    end
  end

  assign load = accept || gap_q;
  assign run  = (idx_q != '0) && !gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      gap_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      gap_q  <= gap_d;
      done_q <= last_end;
    end
  end

endmodule

// File: rtl/ctx_sw_map.sv
module ctx_sw_map
  import ctx_seq_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx_q,
  input  logic             gap_q,
  input  logic [IDX_W-1:0] idx_d,
  input  logic             gap_d,
  output sw_vec_t          sw
);
  generate
    if (OUT_REG) begin : g_reg
      // Registered from next state: glitch-free enables, same timing as state
      sw_vec_t nxt;
      sw_vec_t sw_q;
      always_comb begin
        nxt = gap_d ? gap_pattern(int'(idx_d)) : step_pattern(int'(idx_d));
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sw_q <= '0;
        else        sw_q <= nxt;
      end
      assign sw = sw_q;
    end else begin : g_comb
      logic unused_ok;
      assign unused_ok = clk ^ rst_n ^ gap_d ^ (^idx_d);
      assign sw = gap_q ? gap_pattern(int'(idx_q)) : step_pattern(int'(idx_q));
    end
  endgenerate

endmodule

// File: rtl/ctx_gain_latch.sv
module ctx_gain_latch
  import ctx_seq_pkg::*;
#(
  parameter int          LVL_W    = 8,
  parameter int unsigned LVL_BASE = 192,
  parameter int unsigned LVL_STEP = 8,
  parameter int unsigned LVL_MID  = 184
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [2:0]       gain_in,
  output logic [2:0]       gain_q,
  output logic [LVL_W-1:0] lvl_high,
  output logic [LVL_W-1:0] lvl_low
);
  int unsigned hi_full;
  int unsigned lo_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gain_q <= '0;
    else if (capture) gain_q <= gain_in;
  end

  always_comb begin
    hi_full = lvl_high_of(gain_q, LVL_BASE, LVL_STEP);
    lo_full = lvl_low_of(hi_full, LVL_MID);
  end

  assign lvl_high = LVL_W'(hi_full);
  assign lvl_low  = LVL_W'(lo_full);

endmodule

// File: rtl/ctx_switch_seq.sv
module ctx_switch_seq
  import ctx_seq_pkg::*;
#(
  parameter int          DWELL    = 2,
  parameter bit          OUT_REG  = 1'b1,
  parameter int          LVL_W    = 8,
  parameter int unsigned LVL_BASE = 192,
  parameter int unsigned LVL_STEP = 8,
  parameter int unsigned LVL_MID  = 184
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       gain_in,
  output logic [NSW-1:0]   sw_en,
  output logic             busy,
  output logic             done,
  output logic [2:0]       gain_code,
  output logic [LVL_W-1:0] lvl_high,
  output logic [LVL_W-1:0] lvl_low
);
  // Named internal events, visible to the bound checker
  logic             accept_w;
  logic             step_end_w;
  logic             last_end_w;
  logic             load_w;
  logic             run_w;
  logic [IDX_W-1:0] idx_q_w;
  logic [IDX_W-1:0] idx_d_w;
  logic             gap_q_w;
  logic             gap_d_w;
  sw_vec_t          sw_w;

  ctx_dwell_timer #(.DWELL(DWELL)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load_w),
    .run    (run_w),
    .expire (step_end_w)
  );

  ctx_phase_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .expire   (step_end_w),
    .idx_q    (idx_q_w),
    .gap_q    (gap_q_w),
    .idx_d    (idx_d_w),
    .gap_d    (gap_d_w),
    .accept   (accept_w),
    .load     (load_w),
    .run      (run_w),
    .last_end (last_end_w),
    .done_q   (done)
  );

  ctx_sw_map #(.OUT_REG(OUT_REG)) u_map (
    .clk   (clk),
    .rst_n (rst_n),
    .idx_q (idx_q_w),
    .gap_q (gap_q_w),
    .idx_d (idx_d_w),
    .gap_d (gap_d_w),
    .sw    (sw_w)
  );

  ctx_gain_latch #(
    .LVL_W    (LVL_W),
    .LVL_BASE (LVL_BASE),
    .LVL_STEP (LVL_STEP),
    .LVL_MID  (LVL_MID)
  ) u_gain (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (accept_w),
    .gain_in  (gain_in),
    .gain_q   (gain_code),
    .lvl_high (lvl_high),
    .lvl_low  (lvl_low)
  );

  assign sw_en = sw_w;
  assign busy  = (idx_q_w != '0);

endmodule

// File: rtl/ctx_switch_seq_chk.sv
module ctx_switch_seq_chk
  import ctx_seq_pkg::*;
#(
  parameter int          DWELL   = 2,
  parameter int          LVL_W   = 8,
  parameter int unsigned LVL_MID = 184
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [NSW-1:0]   sw_en,
  input logic             busy,
  input logic             done,
  input logic [2:0]       gain_code,
  input logic [LVL_W-1:0] lvl_high,
  input logic [LVL_W-1:0] lvl_low,
  input logic             accept_w,
  input logic             last_end_w
);
  localparam int SPAN = NSTEP * DWELL + (NSTEP - 1);
  localparam sw_vec_t FIRST = step_pattern(1);

  int span_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        span_q <= 0;
    else if (accept_w) span_q <= 0;
    else if (busy)     span_q <= span_q + 1;
  end

  p_idle_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sw_en == '0);

  p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && sw_en == FIRST));

  p_span_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> span_q == SPAN);

  p_break_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !((|(sw_en & ~$past(sw_en))) && (|(~sw_en & $past(sw_en)))));

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && sw_en == '0));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_last_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    last_end_w |=> done);

  p_no_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(gain_code));

  p_gain_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(start && !busy) |=> $stable(gain_code));

  p_mirror_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(lvl_high) + int'(lvl_low)) == int'(2 * LVL_MID));

  p_excl_s1_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_en[SW_S1] |-> !(sw_en[SW_S2] || sw_en[SW_S3] || sw_en[SW_S5]));

  p_excl_s5_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_en[SW_S5] && sw_en[SW_S6]));

endmodule

bind ctx_switch_seq ctx_switch_seq_chk #(
  .DWELL   (DWELL),
  .LVL_W   (LVL_W),
  .LVL_MID (LVL_MID)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .sw_en      (sw_en),
  .busy       (busy),
  .done       (done),
  .gain_code  (gain_code),
  .lvl_high   (lvl_high),
  .lvl_low    (lvl_low),
  .accept_w   (accept_w),
  .last_end_w (last_end_w)
);

// File: tb/ctx_switch_seq_test.sv
module ctx_switch_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int DWELL      = 2;
  localparam int RUN_LEN    = 9 * DWELL + 8;

  logic       clk;
  logic       rst_n;
  logic       start;
  logic [2:0] gain_in;
  logic [9:0] sw_en;
  logic       busy;
  logic       done;
  logic [2:0] gain_code;
  logic [7:0] lvl_high;
  logic [7:0] lvl_low;

  int  n_checks;
  int  n_fails;
  bit  finished;

  ctx_switch_seq #(.DWELL(DWELL)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .gain_in   (gain_in),
    .sw_en     (sw_en),
    .busy      (busy),
    .done      (done),
    .gain_code (gain_code),
    .lvl_high  (lvl_high),
    .lvl_low   (lvl_low)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // Bench's own statement of the switch map
  function automatic logic [9:0] on(input string name);
    case (name)
      "S1":  return 10'b0000000001;
      "S2":  return 10'b0000000010;
      "S3":  return 10'b0000000100;
      "S4":  return 10'b0000001000;
      "S5":  return 10'b0000010000;
      "S6":  return 10'b0000100000;
      "S7":  return 10'b0001000000;
      "Sr":  return 10'b0010000000;
      "Sc":  return 10'b0100000000;
      "S11": return 10'b1000000000;
      default: return 10'b0;
    endcase
  endfunction

  function automatic logic [9:0] want_step(input int s);
    case (s)
      1: return on("S1") | on("S4") | on("Sr") | on("S11");
      2: return on("S4");
      3: return on("S4") | on("S2");
      4: return on("S2");
      5: return on("S2") | on("Sr") | on("S3") | on("S5");
      6: return on("S2") | on("Sr") | on("S3");
      7: return on("S2") | on("Sr") | on("S3") | on("S6");
      8: return on("S2") | on("Sr") | on("S3");
      9: return on("S2") | on("Sr") | on("S3") | on("S7") | on("Sc");
      default: return 10'b0;
    endcase
  endfunction

  // Cycle k (1-based) after acceptance
  function automatic logic [9:0] want_sw(input int k);
    int s;
    int r;
    s = (k - 1) / (DWELL + 1) + 1;
    r = (k - 1) % (DWELL + 1);
    if (r < DWELL) return want_step(s);
    return want_step(s) & want_step(s + 1);
  endfunction

  function automatic bit is_gap(input int k);
    return ((k - 1) % (DWELL + 1)) == DWELL;
  endfunction

  function automatic int want_hi(input logic [2:0] g);
    return 192 + (int'(g) << 3);
  endfunction

  function automatic int want_lo(input logic [2:0] g);
    return 176 - (int'(g) << 3);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic next_cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_checks(input logic [2:0] g, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      start   = 1'b0;
      gain_in = 3'($urandom);
      next_cycle();
      check("R1 idle switches", int'(sw_en), 0);
      check("R1 idle busy", int'(busy), 0);
      check("R8 gain held in idle", int'(gain_code), int'(g));
    end
  endtask

  // Entered at a negedge with the block idle (or in its done cycle)
  task automatic run_seq(input logic [2:0] g, input bit retrig, input bit chain);
    logic [9:0] prev;
    bit         excl_ok;
    bit         bbm_ok;
    start   = 1'b1;
    gain_in = g;
    prev    = sw_en;
    excl_ok = 1'b1;
    bbm_ok  = 1'b1;
    next_cycle();
    check("R2 first pattern", int'(sw_en), int'(want_step(1)));
    for (int k = 1; k <= RUN_LEN; k++) begin
      if (is_gap(k)) check("R5 gap pattern", int'(sw_en), int'(want_sw(k)));
      else           check("R3 step pattern", int'(sw_en), int'(want_sw(k)));
      check("R4 busy in run", int'(busy), 1);
      check("R6 no early done", int'(done), 0);
      check("R7 gain not reloaded", int'(gain_code), int'(g));
      check("R9 high level", int'(lvl_high), want_hi(g));
      check("R9 low level", int'(lvl_low), want_lo(g));
      if (sw_en[0] && (sw_en[1] || sw_en[2] || sw_en[4])) excl_ok = 1'b0;
      if (sw_en[4] && sw_en[5]) excl_ok = 1'b0;
      if ((|(sw_en & ~prev)) && (|(~sw_en & prev))) bbm_ok = 1'b0;
      prev    = sw_en;
      start   = retrig ? 1'($urandom) : 1'b0;
      gain_in = 3'($urandom);
      next_cycle();
    end
    check("R10 exclusive switches", int'(excl_ok), 1);
    check("R5 no make during break", int'(bbm_ok), 1);
    check("R6 switches off at end", int'(sw_en), 0);
    check("R6 busy low at end", int'(busy), 0);
    check("R6 done pulse", int'(done), 1);
    check("R4 run length", int'(busy), 0);
    if (!chain) begin
      start   = 1'b0;
      gain_in = ~g;
      next_cycle();
      check("R6 done one cycle", int'(done), 0);
      check("R8 gain kept after run", int'(gain_code), int'(g));
    end
  endtask

  initial begin
    n_checks = 0;
    n_fails  = 0;
    finished = 1'b0;
    void'($urandom(32'h1C0FFEE5));
    rst_n   = 1'b0;
    start   = 1'b0;
    gain_in = 3'd5;
    repeat (3) @(negedge clk);
    check("R1 reset switches", int'(sw_en), 0);
    check("R1 reset busy", int'(busy), 0);
    check("R1 reset done", int'(done), 0);
    check("R1 reset gain", int'(gain_code), 0);
    rst_n = 1'b1;
    idle_checks(3'd0, 3);

    // Directed corners: both ends of the gain range, quiet inputs
    run_seq(3'd0, 1'b0, 1'b0);
    idle_checks(3'd0, 2);
    run_seq(3'd7, 1'b0, 1'b0);
    idle_checks(3'd7, 2);
    // Retrigger hammering during a run
    run_seq(3'd3, 1'b1, 1'b0);
    idle_checks(3'd3, 1);
    // Back-to-back: new start offered in the done cycle
    run_seq(3'd6, 1'b0, 1'b1);
    run_seq(3'd1, 1'b0, 1'b0);
    idle_checks(3'd1, 1);

    for (int n = 0; n < 24; n++) begin
      logic [2:0] g;
      g = 3'($urandom);
      run_seq(g, 1'($urandom), 1'b0);
      idle_checks(g, 1 + int'($urandom % 3));
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule